// File: doc/BRIEF.md
# Up-Counting Interval Timer with Event Interrupts

This block is a free-running 32-bit up counter that software programs through a small register bus. Once the start bit is set, the count advances on every clock, or once every power of two clocks when the prescaler is on. When the count passes its all-ones value it either reloads from a load register or stops at zero. A compare register raises a match event when the count reaches it.

Overflow and match events go to a sticky status register with write-one-to-clear bits. An interrupt-enable mask gates which events are recorded, and the interrupt line is high while any recorded bit is set. A separate wakeup-enable mask turns any event into a one-cycle wakeup pulse, whatever the interrupt mask says. Software can write the count directly, force a reload by writing a trigger address, and read the live count.

The bus takes one write or one read address per cycle. Read data is registered and is valid one clock after the address is presented. The output-pin, capture and trigger-mode fields of the control register are stored and read back. No logic in this block acts on them.

Top module: `uptimer`

## Requirements
- R1: While control bit 0 (run) is 1, the count advances by one on each prescaler tick. While it is 0, the count holds.
- R2: An advance from all ones is an overflow. If control bit 1 (reload) is 1, the count takes the load register value. Otherwise the count becomes 0 and the run bit clears.
- R3: When control bit 5 (prescale enable) is 1, a tick occurs once every 2^(P+1) clocks, where P is control bits 4:2. When bit 5 is 0, a tick occurs every clock. Any control write restarts the prescaler, so with P=1 the first tick falls on the fourth clock after the write.
- R4: When control bit 6 (compare enable) is 1, a match event occurs on the tick that makes the count equal to the match register. When bit 6 is 0, no match event occurs.
- R5: Status bit 0 records match, bit 1 records overflow and bit 2 records capture. A bit is recorded only when the same bit of the interrupt-enable register is 1. An overflow and a match on the same tick set both bits together.
- R6: irq_o is 1 exactly when status is nonzero, and it changes in the same cycle as status. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: An event whose wakeup-enable bit is 1 gives a one-cycle pulse on wake_o in the cycle its status would update, even when the interrupt-enable bit is 0.
- R8: Writing any value to the trigger address copies the load register into the count. Reading the trigger address returns all ones. Writing the count address sets the count directly, and reading it returns the live count.
- R9: Word addresses are: 0 identity (reads 0x21), 1 status, 2 interrupt enable, 3 wakeup enable, 4 control, 5 count, 6 load, 7 trigger, 8 match, 9 write-pending (reads 0). The enable registers keep 3 bits and the control register keeps bits 14:0.
- R10: A synchronous reset clears every register, the count, irq_o and wake_o. rdata is registered and shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Word address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Interrupt, high while status is nonzero |
| wake_o | output | 1 | One-cycle wakeup pulse |

## Verification
The bench builds the block with its default 32-bit count and the fixed 3-bit prescale field. It reaches overflow by writing the count one or two steps below all ones, so overflow paths are covered in a handful of cycles. The full prescaler range is also reachable: the largest divide of 256 is checked by waiting exactly 256 clocks after a control write and expecting a single tick.

// File: rtl/uptimer_pkg.sv
package uptimer_pkg;

  localparam int unsigned AW     = 4;
  localparam int unsigned EVT_W  = 3;
  localparam int unsigned PSC_SEL_W = 3;

  localparam int unsigned EV_MATCH = 0;
  localparam int unsigned EV_OVF   = 1;
  localparam int unsigned EV_CAPT  = 2;

  typedef enum logic [AW-1:0] {
    RA_ID    = 4'd0,
    RA_STAT  = 4'd1,
    RA_IEN   = 4'd2,
    RA_WEN   = 4'd3,
    RA_CTRL  = 4'd4,
    RA_CNT   = 4'd5,
    RA_LOAD  = 4'd6,
    RA_TRIG  = 4'd7,
    RA_MATCH = 4'd8,
    RA_WPEND = 4'd9
  } reg_addr_e;

  // Field order is the software-visible bit layout, MSB first
  typedef struct packed {
    logic                 pin_in;
    logic                 cap_second;
    logic                 toggle;
    logic [1:0]           trig_mode;
    logic [1:0]           cap_mode;
    logic                 idle_lvl;
    logic                 cmp_en;
    logic                 psc_en;
    logic [PSC_SEL_W-1:0] psc_val;
    logic                 reload;
    logic                 run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/uptimer_psc.sv
module uptimer_psc #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned PW = 2 ** SEL_W;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] limit;

  // limit holds sel+1 low ones: the last phase of a 2^(sel+1) cycle
  always_comb begin
    limit = '0;
    for (int i = 0; i < PW; i++) begin
      if (i <= int'(sel)) limit[i] = 1'b1;
    end
  end

  wire wrap = (pcnt_q == limit);

  assign tick = run && (!en || wrap);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt_q <= '0;
    end else if (run && en) begin
      pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/uptimer_cnt.sv
module uptimer_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         reload,
  input  logic         cmp_en,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_val,
  input  logic         ld_now,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] match_val,
  output logic [W-1:0] cnt_q,
  output logic         ovf,
  output logic         mat
);
  logic [W-1:0] nxt;

  assign ovf = tick && (&cnt_q);

  always_comb begin
    if (ovf) nxt = reload ? ld_val : '0;
    else     nxt = cnt_q + 1'b1;
  end

  assign mat = tick && cmp_en && (nxt == match_val);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_val;
    else if (ld_now) cnt_q <= ld_val;
    else if (tick)   cnt_q <= nxt;
  end

endmodule

// File: rtl/uptimer_irq.sv
module uptimer_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] ien,
  input  logic [N-1:0] wen,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] status_q,
  output logic         irq_o,
  output logic         wake_o
);
  logic [N-1:0] status_d;

  // a new event wins over a same-cycle clear
  always_comb begin
    status_d = status_q;
    if (clr_we) status_d = status_d & ~clr_mask;
    status_d = status_d | (evt & ien);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_o    <= 1'b0;
      wake_o   <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_o    <= |status_d;
      wake_o   <= |(evt & wen);
    end
  end

endmodule

// File: rtl/uptimer.sv
module uptimer
  import uptimer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter logic [7:0]  ID_VAL = 8'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq_o,
  output logic              wake_o
);
  ctrl_t            ctrl_q;
  logic [EVT_W-1:0] ien_q;
  logic [EVT_W-1:0] wen_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] match_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EVT_W-1:0] status_q;
  logic             tick;
  logic             ovf;
  logic             mat;
  logic [EVT_W-1:0] evt;

  wire we_ctrl  = wr_en && (addr == RA_CTRL);
  wire we_cnt   = wr_en && (addr == RA_CNT);
  wire we_trig  = wr_en && (addr == RA_TRIG);
  wire we_stat  = wr_en && (addr == RA_STAT);

  logic ctl_run;
  logic ctl_reload;
  assign ctl_run    = ctrl_q.run;
  assign ctl_reload = ctrl_q.reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      wen_q   <= '0;
      load_q  <= '0;
      match_q <= '0;
    end else begin
      if (we_ctrl)                           ctrl_q     <= ctrl_t'(wdata[CTRL_W-1:0]);
      else if (ovf && !ctrl_q.reload)        ctrl_q.run <= 1'b0;
      if (wr_en && addr == RA_IEN)           ien_q      <= wdata[EVT_W-1:0];
      if (wr_en && addr == RA_WEN)           wen_q      <= wdata[EVT_W-1:0];
      if (wr_en && addr == RA_LOAD)          load_q     <= wdata;
      if (wr_en && addr == RA_MATCH)         match_q    <= wdata;
    end
  end

  uptimer_psc #(.SEL_W(PSC_SEL_W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .clr  (we_ctrl),
    .run  (ctrl_q.run),
    .en   (ctrl_q.psc_en),
    .sel  (ctrl_q.psc_val),
    .tick (tick)
  );

  uptimer_cnt #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .reload    (ctrl_q.reload),
    .cmp_en    (ctrl_q.cmp_en),
    .wr_cnt    (we_cnt),
    .wr_val    (wdata),
    .ld_now    (we_trig),
    .ld_val    (load_q),
    .match_val (match_q),
    .cnt_q     (cnt_q),
    .ovf       (ovf),
    .mat       (mat)
  );

  // capture has no source pin in this block; its status bit is clear-only
  always_comb begin
    evt           = '0;
    evt[EV_MATCH] = mat;
    evt[EV_OVF]   = ovf;
  end

  uptimer_irq #(.N(EVT_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .ien      (ien_q),
    .wen      (wen_q),
    .clr_we   (we_stat),
    .clr_mask (wdata[EVT_W-1:0]),
    .status_q (status_q),
    .irq_o    (irq_o),
    .wake_o   (wake_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        RA_ID:    rdata <= CNT_W'(ID_VAL);
        RA_STAT:  rdata <= CNT_W'(status_q);
        RA_IEN:   rdata <= CNT_W'(ien_q);
        RA_WEN:   rdata <= CNT_W'(wen_q);
        RA_CTRL:  rdata <= CNT_W'(ctrl_q);
        RA_CNT:   rdata <= cnt_q;
        RA_LOAD:  rdata <= load_q;
        RA_TRIG:  rdata <= '1;
        RA_MATCH: rdata <= match_q;
        default:  rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/uptimer_chk.sv
module uptimer_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             irq,
  input logic             wake,
  input logic [N-1:0]     status,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] match,
  input logic             run,
  input logic             reload
);

  a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!$past(run) && !$past(wr_en)) |-> (count == $past(count)));

  a_r2_ovf_from_max: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> ($past(count) == '1));

  a_r2_stop_clears: assert property (@(posedge clk) disable iff (rst)
    ($rose(status[1]) && !$past(reload) && !$past(wr_en)) |-> (count == '0 && !run));

  a_r4_match_value: assert property (@(posedge clk) disable iff (rst)
    ($rose(status[0]) && !$past(wr_en)) |-> (count == match));

  a_r6_irq_follows_status: assert property (@(posedge clk) disable iff (rst)
    irq == (status != '0));

  a_r7_wake_needs_run: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(run));

endmodule

bind uptimer uptimer_chk #(.CNT_W(CNT_W), .N(uptimer_pkg::EVT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .irq    (irq_o),
  .wake   (wake_o),
  .status (status_q),
  .count  (cnt_q),
  .match  (match_q),
  .run    (ctl_run),
  .reload (ctl_reload)
);

// File: tb/uptimer_tb.sv
module uptimer_tb;
  import uptimer_pkg::*;

  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [3:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq_o;
  logic         wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uptimer u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  // {write, addr, data, expected read}
  localparam int NV = 17;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 4'd0, 32'h0,        32'h21},        // R9 identity
    {1'b1, 4'd2, 32'hFF,       32'h0},
    {1'b0, 4'd2, 32'h0,        32'h7},         // R9 3-bit mask
    {1'b1, 4'd3, 32'h5,        32'h0},
    {1'b0, 4'd3, 32'h0,        32'h5},
    {1'b1, 4'd6, 32'h1234,     32'h0},
    {1'b0, 4'd6, 32'h0,        32'h1234},
    {1'b1, 4'd8, 32'hABCD,     32'h0},
    {1'b0, 4'd8, 32'h0,        32'hABCD},
    {1'b0, 4'd7, 32'h0,        32'hFFFFFFFF},  // R8 trigger reads ones
    {1'b0, 4'd9, 32'h0,        32'h0},         // R9 write-pending
    {1'b1, 4'd7, 32'h9,        32'h0},
    {1'b0, 4'd5, 32'h0,        32'h1234},      // R8 trigger reload
    {1'b1, 4'd5, 32'h55,       32'h0},
    {1'b0, 4'd5, 32'h0,        32'h55},        // R8 direct write
    {1'b1, 4'd4, 32'hFFFFFFFE, 32'h0},
    {1'b0, 4'd4, 32'h0,        32'h7FFE}       // R9 control width
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    chk("R10 irq after reset", W'(irq_o), 0);
    chk("R10 wake after reset", W'(wake_o), 0);
    rd(4'd5, v); chk("R10 count after reset", v, 0);
    rd(4'd4, v); chk("R10 ctrl after reset", v, 0);
    rd(4'd1, v); chk("R10 status after reset", v, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][68]) wr(VEC[i][67:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][67:64], v);
        chk("R9/R8 table read", v, VEC[i][31:0]);
      end
    end
    wr(4'd4, 0);

    // R1 plain counting: 5 ticks
    wr(4'd5, 10); wr(4'd4, 1);
    repeat (4) @(negedge clk);
    wr(4'd4, 0);
    rd(4'd5, v); chk("R1 count after 5 clocks", v, 15);
    repeat (3) @(negedge clk);
    rd(4'd5, v); chk("R1 hold while stopped", v, 15);

    // R3 divide by 4
    wr(4'd5, 0); wr(4'd4, 32'h25);
    repeat (16) @(negedge clk);
    wr(4'd4, 0);
    rd(4'd5, v); chk("R3 divide-by-4 over 17 clocks", v, 4);

    // R3 divide by 256
    wr(4'd5, 0); wr(4'd4, 32'h3D);
    repeat (255) @(negedge clk);
    wr(4'd4, 0);
    rd(4'd5, v); chk("R3 divide-by-256 one tick", v, 1);

    // R2 overflow with reload
    wr(4'd2, 7); wr(4'd3, 5); wr(4'd6, 32'h100);
    wr(4'd5, 32'hFFFFFFFE); wr(4'd4, 3);
    @(negedge clk); @(negedge clk);
    chk("R6 irq on overflow", W'(irq_o), 1);
    chk("R7 no wake when masked", W'(wake_o), 0);
    wr(4'd4, 2);
    rd(4'd5, v); chk("R2 reload then one tick", v, 32'h101);
    rd(4'd1, v); chk("R5 overflow status bit", v, 2);
    wr(4'd1, 2);
    chk("R6 irq cleared by W1C", W'(irq_o), 0);
    rd(4'd1, v); chk("R6 status cleared", v, 0);

    // R2 overflow without reload, R7 wake pulse
    wr(4'd3, 2); wr(4'd5, 32'hFFFFFFFF); wr(4'd4, 1);
    @(negedge clk);
    chk("R7 wake pulse on overflow", W'(wake_o), 1);
    chk("R6 irq on overflow", W'(irq_o), 1);
    @(negedge clk);
    chk("R7 wake lasts one cycle", W'(wake_o), 0);
    rd(4'd4, v); chk("R2 run bit cleared", v, 0);
    rd(4'd5, v); chk("R2 count cleared", v, 0);
    wr(4'd1, 7);

    // R4 match, R5 overflow masked off
    wr(4'd2, 1); wr(4'd3, 0); wr(4'd8, 32'h20);
    wr(4'd5, 32'h1E); wr(4'd4, 32'h41);
    @(negedge clk);
    chk("R4 no irq before match", W'(irq_o), 0);
    @(negedge clk);
    chk("R4 irq on match", W'(irq_o), 1);
    wr(4'd4, 0);
    rd(4'd1, v); chk("R5 match status bit", v, 1);
    wr(4'd1, 1);

    // R4 compare disabled
    wr(4'd5, 32'h1E); wr(4'd4, 1);
    repeat (4) @(negedge clk);
    wr(4'd4, 0);
    rd(4'd1, v); chk("R4 no match with compare off", v, 0);
    chk("R4 irq stays low", W'(irq_o), 0);

    // R7 wake with interrupt disabled, R5 masked status
    wr(4'd2, 0); wr(4'd3, 1);
    wr(4'd5, 32'h1E); wr(4'd4, 32'h41);
    @(negedge clk);
    chk("R7 no wake before match", W'(wake_o), 0);
    @(negedge clk);
    chk("R7 wake with irq disabled", W'(wake_o), 1);
    wr(4'd4, 0);
    rd(4'd1, v); chk("R5 masked event not recorded", v, 0);

    // R5 overflow and match on same tick
    wr(4'd2, 3); wr(4'd3, 0); wr(4'd6, 32'h40); wr(4'd8, 32'h40);
    wr(4'd5, 32'hFFFFFFFF); wr(4'd4, 32'h43);
    @(negedge clk);
    wr(4'd4, 0);
    rd(4'd1, v); chk("R5 both bits set together", v, 3);
    wr(4'd1, 1);
    rd(4'd1, v); chk("R6 write 0 leaves bit", v, 2);
    chk("R6 irq still high", W'(irq_o), 1);

    done = 1;
    finish_run();
  end

endmodule